// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands and returns their 32-bit product. It has no clock and no state, so the output follows the operands in the same cycle. The sign bit is bit 31, the biased exponent is bits 30 to 23, and the fraction is bits 22 to 0. Each operand is split into these fields. The hidden leading one is restored, which gives a 24-bit significand. The two significands are multiplied into a 48-bit product. A leading-one search normalizes that product and sets how far the exponent must move. Exponent work runs in a 9-bit signed path: the bias of 127 comes off each operand, the two exponents are summed, the normalization step is applied, and the bias goes back on. The fraction is truncated, not rounded.

Operands with a zero exponent field count as zero. Results outside the normal range either saturate to infinity or flush to zero. Operands with an all-ones exponent field are outside the supported range, and the block gives no defined result for them.

Top module: `fpm_mul`

## Requirements
- R1: The result sign (bit 31) is the XOR of the two operand signs in every case, including zero and infinity results.
- R2: For finite normal operands whose product is in range, the result equals the exact 48-bit significand product, normalized, re-biased and truncated to 23 fraction bits.
- R3: When the significand product has its leading one at bit 47, the result exponent field is ea + eb - 127 + 1, where ea and eb are the operand exponent fields.
- R4: When the significand product has its leading one at bit 46, the result exponent field is ea + eb - 127 and the fraction is taken from product bits 45 down to 23.
- R5: If either operand has an exponent field of 0, the result is a signed zero: the XOR sign, with bits 30 to 0 all clear.
- R6: If the re-biased result exponent is 255 or more, the result is signed infinity: exponent field 255 and fraction 0.
- R7: If the re-biased result exponent is 0 or less, the result is a signed zero with bits 30 to 0 clear.
- R8: Fraction bits below the kept 23 are discarded and never rounded up, so (1+2^-23)×(1+2^-23) gives 0x3F800002.
- R9: The result depends only on the present operands. It is valid in the same cycle as they are, with no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand: sign, biased exponent, fraction |
| op_b | input | 32 | Second operand: same layout |
| result | output | 32 | Truncated product in the same layout |

## Verification
The block is purely combinational, so each result is due in the same cycle as the operands that produce it. The driver applies a pair of operands on a rising edge and queues the expected word. The monitor pops and compares that word on the falling edge of the same cycle. Every result is therefore sampled half a period after its operands settle and before the next pair arrives. Hand-picked pairs cover both normalization cases, truncation, signed zeros, and the overflow and underflow boundaries. Randomly drawn normal operands are then checked against a reference model written in the bench.

// File: rtl/fpm_pkg.sv
// Package for the floating-point multiplier.
// Holds the default format widths and the operation code of the exponent adder.
// Assumes a binary interchange layout of sign, biased exponent and fraction.
package fpm_pkg;
    localparam int FPM_EXP_W  = 8;
    localparam int FPM_FRAC_W = 23;

    typedef enum logic {
        XOP_ADD = 1'b0,
        XOP_SUB = 1'b1
    } xop_e;
endpackage

// File: rtl/fpm_exp_alu.sv
// Narrow signed adder/subtractor for the exponent path.
// It flags two's-complement overflow so the caller can saturate.
// Assumes both operands are already sign-correct W-bit values.
module fpm_exp_alu
    import fpm_pkg::*;
#(
    parameter int W = 9
) (
    input  xop_e                op,
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] y,
    output logic signed [W-1:0] z,
    output logic                ovf
);
    // add or subtract, then detect a sign mismatch that marks overflow
    always_comb begin
        if (op == XOP_ADD) begin
            z   = x + y;
            ovf = (x[W-1] == y[W-1]) && (z[W-1] != x[W-1]);
        end else begin
            z   = x - y;
            ovf = (x[W-1] != y[W-1]) && (z[W-1] != x[W-1]);
        end
    end
endmodule

// File: rtl/fpm_unpack.sv
// Splits one operand into its fields and restores the hidden one.
// A zero exponent field is reported as a zero operand; subnormals are not handled.
module fpm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0]   word,
    output logic              sgn,
    output logic [EXP_W-1:0]  exp_field,
    output logic [FRAC_W:0]   sig,
    output logic              is_zero
);
    // field extraction and hidden-one insertion
    always_comb begin
        sgn       = word[OP_W-1];
        exp_field = word[OP_W-2 -: EXP_W];
        sig       = {1'b1, word[FRAC_W-1:0]};
        is_zero   = (exp_field == '0);
    end
endmodule

// File: rtl/fpm_norm.sv
// Leading-one search and left shift over the significand product.
// Reports the shift amount so the exponent can be corrected by (1 - lz).
// Assumes a non-zero product; a zero product yields lz = 0.
module fpm_norm #(
    parameter int PROD_W = 48,
    localparam int LZ_W  = $clog2(PROD_W)
) (
    input  logic [PROD_W-1:0] prod,
    output logic [PROD_W-1:0] shifted,
    output logic [LZ_W-1:0]   lz
);
    // scan upward so the highest set bit decides the shift
    always_comb begin
        lz = '0;
        for (int i = 0; i < PROD_W; i++) begin
            if (prod[i]) lz = LZ_W'(PROD_W - 1 - i);
        end
        shifted = prod << lz;
    end
endmodule

// File: rtl/fpm_mul.sv
// Combinational floating-point multiplier, truncating, no exception flags.
// Assumes finite operands; an all-ones exponent field is outside its range.
// Exponents run through a (EXP_W+1)-bit signed path: unbias, sum, normalize, rebias.
module fpm_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = FPM_EXP_W,
    parameter int FRAC_W = FPM_FRAC_W
) (
    input  logic [1+EXP_W+FRAC_W-1:0] op_a,
    input  logic [1+EXP_W+FRAC_W-1:0] op_b,
    output logic [1+EXP_W+FRAC_W-1:0] result
);
    localparam int OP_W   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 1;
    localparam int LZ_W   = $clog2(PROD_W);
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic signed [XW-1:0] BIAS_S = XW'(BIAS);
    localparam logic signed [XW-1:0] EMAX_S = XW'(EMAX);

    logic [OP_W-1:0]          ops      [2];
    logic                     sgn      [2];
    logic [EXP_W-1:0]         efield   [2];
    logic [SIG_W-1:0]         sig      [2];
    logic                     zro      [2];
    logic signed [XW-1:0]     eub      [2];
    logic                     eub_ovf  [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // per-operand unpack and bias removal
    for (genvar k = 0; k < 2; k++) begin : g_opnd
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_i (
            .word      (ops[k]),
            .sgn       (sgn[k]),
            .exp_field (efield[k]),
            .sig       (sig[k]),
            .is_zero   (zro[k])
        );
        fpm_exp_alu #(.W(XW)) unbias_i (
            .op  (XOP_SUB),
            .x   ($signed({1'b0, efield[k]})),
            .y   (BIAS_S),
            .z   (eub[k]),
            .ovf (eub_ovf[k])
        );
    end

    logic                     sgn_out;
    logic [PROD_W-1:0]        prod;
    logic [PROD_W-1:0]        prod_n;
    logic [LZ_W-1:0]          lz;
    logic signed [XW-1:0]     e_sum, e_adj, e_norm, e_rb;
    logic                     sum_ovf, norm_ovf, rb_ovf;

    // sign and full-width significand product
    always_comb begin
        sgn_out = sgn[0] ^ sgn[1];
        prod    = PROD_W'(sig[0]) * PROD_W'(sig[1]);
    end

    fpm_norm #(.PROD_W(PROD_W)) norm_i (
        .prod    (prod),
        .shifted (prod_n),
        .lz      (lz)
    );

    // exponent step from normalization: +1 for no shift, 0 for one shift
    always_comb e_adj = $signed(XW'(1)) - $signed({{(XW-LZ_W){1'b0}}, lz});

    fpm_exp_alu #(.W(XW)) sum_i (
        .op (XOP_ADD), .x (eub[0]), .y (eub[1]), .z (e_sum), .ovf (sum_ovf)
    );
    fpm_exp_alu #(.W(XW)) adj_i (
        .op (XOP_ADD), .x (e_sum), .y (e_adj), .z (e_norm), .ovf (norm_ovf)
    );
    fpm_exp_alu #(.W(XW)) rebias_i (
        .op (XOP_ADD), .x (e_norm), .y (BIAS_S), .z (e_rb), .ovf (rb_ovf)
    );

    logic unused_bits;
    assign unused_bits = ^{eub_ovf[0], eub_ovf[1], sum_ovf, norm_ovf,
                           prod_n[PROD_W-1], prod_n[PROD_W-FRAC_W-2:0]};

    // zero, saturation, flush or pack
    always_comb begin
        if (zro[0] || zro[1]) begin
            result = {sgn_out, {(OP_W-1){1'b0}}};
        end else if (rb_ovf || (e_rb >= EMAX_S)) begin
            result = {sgn_out, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e_rb <= $signed(XW'(0))) begin
            result = {sgn_out, {(OP_W-1){1'b0}}};
        end else begin
            result = {sgn_out, e_rb[EXP_W-1:0], prod_n[PROD_W-2 -: FRAC_W]};
        end
    end
endmodule

// File: rtl/fpm_mul_chk.sv
// Checker for fpm_mul: relates operand fields to result fields at the ports.
// Checks are immediate and skipped while any port carries unknown bits.
module fpm_mul_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input logic [OP_W-1:0] op_a,
    input logic [OP_W-1:0] op_b,
    input logic [OP_W-1:0] result
);
    localparam int EW   = EXP_W + 4;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 1;

    logic [EXP_W-1:0]     ea, eb, er;
    logic signed [EW-1:0] est, er_s;
    logic                 known, both_nz;

    assign ea      = op_a[OP_W-2 -: EXP_W];
    assign eb      = op_b[OP_W-2 -: EXP_W];
    assign er      = result[OP_W-2 -: EXP_W];
    assign est     = $signed(EW'(ea)) + $signed(EW'(eb)) - $signed(EW'(BIAS));
    assign er_s    = $signed(EW'(er));
    assign known   = !$isunknown({op_a, op_b, result});
    assign both_nz = (ea != '0) && (eb != '0);

    // port-level relations between operands and product
    always_comb begin
        if (known) begin
            p_sign_xor_r1: assert (result[OP_W-1] == (op_a[OP_W-1] ^ op_b[OP_W-1]))
                else $error("sign is not the XOR of operand signs");
            p_zero_in_r5: assert (both_nz || (result[OP_W-2:0] == '0))
                else $error("zero operand did not give signed zero");
            p_inf_frac_r6: assert ((er != EXP_W'(EMAX)) || (result[FRAC_W-1:0] == '0))
                else $error("all-ones exponent with non-zero fraction");
            p_no_overflow_r6: assert (!(both_nz && (est >= $signed(EW'(EMAX)))) || (er == EXP_W'(EMAX)))
                else $error("exponent overflow did not saturate");
            p_underflow_r7: assert (!(both_nz && (est + $signed(EW'(1)) <= $signed(EW'(0))))
                                    || (result[OP_W-2:0] == '0))
                else $error("exponent underflow did not flush");
            p_exp_step_r3: assert (!(both_nz && (er != '0) && (er != EXP_W'(EMAX)))
                                   || (er_s == est) || (er_s == est + $signed(EW'(1))))
                else $error("result exponent off the two normalization cases");
        end
    end
endmodule

bind fpm_mul fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result)
);

// File: tb/fpm_mul_tb_top.sv
// Scoreboard bench for fpm_mul: the driver queues expected words,
// and the monitor compares them on the falling edge of the same cycle.
module fpm_mul_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];
    item_t it;

    fpm_mul dut_i (.op_a(op_a), .op_b(op_b), .result(result));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // reference product built from the requirements
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic        s;
        logic [63:0] p;
        int          e;
        logic [22:0] f;
        s = a[31] ^ b[31];
        if (a[30:23] == 0 || b[30:23] == 0) return {s, 31'b0};
        p = 64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]});
        e = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (p[47]) begin
            e = e + 1;
            f = p[46:24];
        end else begin
            f = p[45:23];
        end
        if (e >= 255) return {s, 8'hFF, 23'b0};
        if (e <= 0) return {s, 31'b0};
        return {s, e[7:0], f};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp, input string req);
        item_t x;
        @(posedge clk);
        op_a <= a;
        op_b <= b;
        x.a = a; x.b = b; x.exp = exp; x.req = req;
        sb.push_back(x);
    endtask

    // monitor: result is due in the same cycle as its operands
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            it = sb.pop_front();
            check(it.req, result, it.exp);
        end
    end

    // watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state: zero operands give a zero result (R5)
        repeat (2) @(negedge clk);
        check("R5 reset", result, 32'h0000_0000);
        @(posedge clk);
        rst_n <= 1'b1;

        // leading one at bit 46: no increment (R4)
        drive(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, "R4 1*1");
        drive(32'h3FA0_0000, 32'h3FA0_0000, 32'h3FC8_0000, "R4 1.25*1.25");
        // leading one at bit 47: increment (R3)
        drive(32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, "R3 1.5*1.5");
        drive(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, "R3 2*3");
        // sign handling (R1)
        drive(32'hBFC0_0000, 32'h4000_0000, 32'hC040_0000, "R1 -1.5*2");
        drive(32'hC000_0000, 32'hC040_0000, 32'h40C0_0000, "R1 -2*-3");
        // zero operands (R5)
        drive(32'h8000_0000, 32'h3F80_0000, 32'h8000_0000, "R5 -0*1");
        drive(32'h0000_0000, 32'hC0A0_0000, 32'h8000_0000, "R5 0*-5");
        drive(32'h4040_0000, 32'h0000_0000, 32'h0000_0000, "R5 3*0");
        // overflow boundary (R6)
        drive(32'h7F00_0000, 32'h3F80_0000, 32'h7F00_0000, "R6 edge 254");
        drive(32'h7F00_0000, 32'h4000_0000, 32'h7F80_0000, "R6 edge 255");
        drive(32'h7F7F_FFFF, 32'h4000_0000, 32'h7F80_0000, "R6 max*2");
        drive(32'hFF7F_FFFF, 32'h4000_0000, 32'hFF80_0000, "R6 -max*2");
        // underflow boundary (R7)
        drive(32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, "R7 edge 1");
        drive(32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, "R7 edge 0");
        drive(32'h3F7F_FFFF, 32'h0080_0000, 32'h0000_0000, "R7 no-inc 0");
        drive(32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, "R7 signed");
        drive(32'h0080_0000, 32'h0080_0000, 32'h0000_0000, "R7 tiny*tiny");
        // truncation, not rounding (R8)
        drive(32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0002, "R8 (1+u)^2");
        drive(32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0001, "R8 (1+u)*1.5");
        drive(32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE, "R8 max sig");

        // random normal operands against the reference (R2, R9)
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a, b;
            a = {1'($urandom), 8'(1 + ($urandom % 254)), 23'($urandom)};
            b = {1'($urandom), 8'(1 + ($urandom % 254)), 23'($urandom)};
            drive(a, b, ref_mul(a, b), "R2 random");
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule